// File: doc/BRIEF.md
# I2C Byte Shifter with Programmable Data Delay

This block moves the serial data of one I2C byte slot between a parallel transmit or receive word and the open-drain data line. A slot holds eight data bits and a ninth acknowledge bit. A clock generator outside the block supplies single-cycle pulses that mark the falling and rising edges of the transfer clock. It also supplies a divider tick, which is the time base for the data output delay.

On transmit, a loaded 9-bit word is shifted out most significant bit first, one bit for each falling edge. The acknowledge slot comes last. After that the line is released. Each new level can reach the line at once or after a programmed number of divider ticks. A release control forces the driver off whatever is being shifted. While the port is in I2C mode with the serial function switched off, the idle data level can be preset.

On receive, the data line is sampled on each rising edge. The nine samples are packed into a receive word using either the standard layout or a split layout that keeps the eighth bit next to the acknowledge bit. A one-cycle completion pulse follows the ninth sample.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset `sda_drive_low` is 0 (line released), `rx_word` is 0 and `rx_done` is 0.
- R2: With `dly_sel`=0, each falling-edge pulse puts the next bit of `tx_data` on the line, in the order bit 8 down to bit 0, where bit 0 is the acknowledge slot. Every later falling edge gives a released (high) level. The new level is visible in the cycle after the pulse.
- R3: A `dly_sel` value n from 1 to 7 delays the level change by n+1 divider ticks after the falling edge. The change is visible in the cycle after the (n+1)th tick. A newer falling edge first applies any level still pending.
- R4: While `sda_release` is 1, `sda_drive_low` is 0, and shifting continues underneath.
- R5: A pulse on `preset_we` sets the line level to `preset_level`, but only while `i2c_mode`=1 and `enable`=0. Otherwise it has no effect.
- R6: Standard layout (`split_pack`=0): received bits 1..8 land in `rx_word[7:0]` with bit 1 in position 7, and bit 9 lands in `rx_word[8]`. The word is written in the cycle after the ninth rising edge.
- R7: Split layout (`split_pack`=1, `ack_std_view`=0): after the eighth rising edge, `rx_word[6:0]` holds bits 1..7 (bit 1 in position 6), `rx_word[8]` holds bit 8 and `rx_word[7]` is 0. After the ninth rising edge, `rx_word[7]` holds bit 9.
- R8: With `split_pack`=1 and `ack_std_view`=1, the ninth rising edge writes the standard layout of R6.
- R9: `rx_done` is high for exactly one cycle, in the cycle after each ninth rising edge, and is low at all other times.
- R10: Edge pulses are ignored unless `i2c_mode`=1 and `enable`=1. Neither the line level nor the receive word changes.
- R11: `tx_load` restarts the receive bit count, so the next rising edge is bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2c_mode | input | 1 | Port is in I2C mode |
| enable | input | 1 | Serial function enabled |
| scl_fall | input | 1 | Transfer-clock falling-edge pulse |
| scl_rise | input | 1 | Transfer-clock rising-edge pulse |
| div_tick | input | 1 | Divider source tick used for the output delay |
| dly_sel | input | 3 | 0: no delay; n: n+1 ticks |
| sda_release | input | 1 | Forces the data driver off |
| preset_we | input | 1 | Preset strobe for the idle data level |
| preset_level | input | 1 | Level written by the preset strobe |
| tx_load | input | 1 | Loads `tx_data` and restarts the receive count |
| tx_data | input | 9 | Bits 8..1 data MSB first, bit 0 acknowledge slot |
| split_pack | input | 1 | Selects the split receive layout |
| ack_std_view | input | 1 | Split layout shows the standard layout at the ninth edge |
| sda_in | input | 1 | Sampled data line |
| sda_drive_low | output | 1 | 1 pulls the open-drain line low |
| rx_word | output | 9 | Receive word |
| rx_done | output | 1 | One-cycle pulse after the ninth sample |

## Verification
The line level is due in the cycle after a falling-edge pulse when no delay is set. With a delay, it is due in the cycle after the (n+1)th divider tick that follows the edge. The receive word and the completion pulse are due in the cycle after the rising-edge pulse that completes a bit count. The bench drives every input on the falling clock edge and compares the three outputs against a behavioural model on every falling edge. Each comparison therefore sees the state registered at the preceding rising edge, so every result is checked in the exact cycle it is due. Targeted checks after partial and complete bytes pin down the layout values and the pulse count.

// File: rtl/i2csh_pkg.sv
package i2csh_pkg;
    typedef enum logic {
        LAYOUT_STD   = 1'b0,
        LAYOUT_SPLIT = 1'b1
    } layout_e;

    // Reload value for the delay counter: code n means n+1 ticks.
    function automatic logic [3:0] dly_reload(input logic [2:0] code);
        return {1'b0, code} + 4'd1;
    endfunction
endpackage

// File: rtl/i2csh_tx.sv
module i2csh_tx #(
    parameter int DW    = 8,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             preset_ok,
    input  logic             scl_fall,
    input  logic             div_tick,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             preset_we,
    input  logic             preset_level,
    input  logic             tx_load,
    input  logic [DW:0]      tx_data,
    output logic             level
);
    localparam int SW = DW + 1;
    localparam int CW = DLY_W + 1;

    typedef struct packed {
        logic [SW-1:0] shift;
        logic          lvl;
        logic          pend;
        logic          plvl;
        logic [CW-1:0] dcnt;
    } tx_st_t;

    tx_st_t st_q, st_d;
    logic   nbit;

    always_comb begin
        st_d = st_q;
        nbit = st_q.shift[SW-1];
        // pending level counts down on divider ticks
        if (st_q.pend && div_tick) begin
            if (st_q.dcnt == CW'(1)) begin
                st_d.lvl  = st_q.plvl;
                st_d.pend = 1'b0;
            end else begin
                st_d.dcnt = st_q.dcnt - CW'(1);
            end
        end
        if (active && scl_fall) begin
            st_d.shift = {st_q.shift[SW-2:0], 1'b1};
            if (st_q.pend) begin
                st_d.lvl = st_q.plvl;
            end
            if (dly_sel == '0) begin
                st_d.lvl  = nbit;
                st_d.pend = 1'b0;
            end else begin
                st_d.plvl = nbit;
                st_d.pend = 1'b1;
                st_d.dcnt = {1'b0, dly_sel} + CW'(1);
            end
        end
        if (tx_load) begin
            st_d.shift = tx_data;
        end
        if (preset_we && preset_ok) begin
            st_d.lvl  = preset_level;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shift <= '1;
            st_q.lvl   <= 1'b1;
            st_q.pend  <= 1'b0;
            st_q.plvl  <= 1'b1;
            st_q.dcnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/i2csh_rx.sv
module i2csh_rx #(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                scl_rise,
    input  logic                sda_in,
    input  logic                restart,
    input  i2csh_pkg::layout_e  layout,
    input  logic                ack_std_view,
    output logic [DW:0]         word,
    output logic                done
);
    localparam int SW   = DW + 1;
    localparam int CNTW = $clog2(SW + 1);

    typedef struct packed {
        logic [SW-1:0]   raw;
        logic [CNTW-1:0] cnt;
        logic [SW-1:0]   word;
        logic            done;
    } rx_st_t;

    rx_st_t        st_q, st_d;
    logic [SW-1:0] sh;
    logic          split;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sh        = {st_q.raw[SW-2:0], sda_in};
        split     = (layout == i2csh_pkg::LAYOUT_SPLIT);
        if (active && scl_rise) begin
            st_d.raw = sh;
            if (st_q.cnt == CNTW'(DW)) begin
                st_d.cnt  = '0;
                st_d.done = 1'b1;
                if (split && !ack_std_view) begin
                    st_d.word = {sh[1], sh[0], sh[SW-1:2]};
                end else begin
                    st_d.word = {sh[0], sh[SW-1:1]};
                end
            end else begin
                st_d.cnt = st_q.cnt + CNTW'(1);
                if (split && (st_q.cnt == CNTW'(DW - 1))) begin
                    st_d.word = {sh[0], 1'b0, sh[DW-1:1]};
                end
            end
        end
        if (restart) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign done = st_q.done;
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
    parameter int DW    = 8,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i2c_mode,
    input  logic             enable,
    input  logic             scl_fall,
    input  logic             scl_rise,
    input  logic             div_tick,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             sda_release,
    input  logic             preset_we,
    input  logic             preset_level,
    input  logic             tx_load,
    input  logic [DW:0]      tx_data,
    input  logic             split_pack,
    input  logic             ack_std_view,
    input  logic             sda_in,
    output logic             sda_drive_low,
    output logic [DW:0]      rx_word,
    output logic             rx_done
);
    logic               active;
    logic               preset_ok;
    logic               level;
    i2csh_pkg::layout_e layout;

    assign active    = i2c_mode & enable;
    assign preset_ok = i2c_mode & ~enable;
    assign layout    = split_pack ? i2csh_pkg::LAYOUT_SPLIT : i2csh_pkg::LAYOUT_STD;

    i2csh_tx #(.DW(DW), .DLY_W(DLY_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .preset_ok    (preset_ok),
        .scl_fall     (scl_fall),
        .div_tick     (div_tick),
        .dly_sel      (dly_sel),
        .preset_we    (preset_we),
        .preset_level (preset_level),
        .tx_load      (tx_load),
        .tx_data      (tx_data),
        .level        (level)
    );

    i2csh_rx #(.DW(DW)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .scl_rise     (scl_rise),
        .sda_in       (sda_in),
        .restart      (tx_load),
        .layout       (layout),
        .ack_std_view (ack_std_view),
        .word         (rx_word),
        .done         (rx_done)
    );

    assign sda_drive_low = ~sda_release & ~level;
endmodule

// File: rtl/i2csh_chk.sv
module i2csh_chk #(
    parameter int DW    = 8,
    parameter int DLY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i2c_mode,
    input logic             enable,
    input logic             scl_fall,
    input logic             scl_rise,
    input logic             div_tick,
    input logic [DLY_W-1:0] dly_sel,
    input logic             sda_release,
    input logic             preset_we,
    input logic             preset_level,
    input logic             tx_load,
    input logic [DW:0]      tx_data,
    input logic             split_pack,
    input logic             ack_std_view,
    input logic             sda_in,
    input logic             sda_drive_low,
    input logic [DW:0]      rx_word,
    input logic             rx_done
);
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R9, R10: completion only follows an accepted rising edge
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(scl_rise && i2c_mode && enable));

    // R6, R10: receive word moves only after an accepted rising edge
    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> $past(scl_rise && i2c_mode && enable));

    // R5: an accepted preset sets the line level
    p_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(preset_we && i2c_mode && !enable)
        |-> (sda_drive_low == (!$past(preset_level) && !sda_release)));
endmodule

bind i2c_byte_shifter i2csh_chk #(.DW(DW), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/tb_i2c_byte_shifter.sv
module tb_i2c_byte_shifter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       i2c_mode, enable, scl_fall, scl_rise, div_tick;
    logic [2:0] dly_sel;
    logic       sda_release, preset_we, preset_level, tx_load;
    logic [8:0] tx_data;
    logic       split_pack, ack_std_view, sda_in;
    logic       sda_drive_low;
    logic [8:0] rx_word;
    logic       rx_done;

    always #5 clk = ~clk;

    i2c_byte_shifter dut (.*);

    integer vec = 0, mis = 0, done_seen = 0;
    integer tc = 0;
    string  cur_req = "R1";

    // reference model state
    integer     m_pos, m_wait;
    logic [8:0] m_txw, m_word;
    logic       m_lvl, m_plvl, m_done;
    bit         m_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            mis++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        tc = tc + 1;
        div_tick = tc[0];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 9; m_wait = 0; m_txw = '1; m_lvl = 1'b1; m_plvl = 1'b1;
            m_word = '0; m_done = 1'b0; m_q.delete();
        end else begin
            logic nb;
            m_done = 1'b0;
            if (m_wait > 0 && div_tick) begin
                m_wait--;
                if (m_wait == 0) m_lvl = m_plvl;
            end
            if (i2c_mode && enable && scl_fall) begin
                if (m_wait > 0) m_lvl = m_plvl;
                nb = (m_pos < 9) ? m_txw[8-m_pos] : 1'b1;
                m_pos++;
                if (dly_sel == 0) begin m_lvl = nb; m_wait = 0; end
                else begin m_plvl = nb; m_wait = dly_sel + 1; end
            end
            if (i2c_mode && enable && scl_rise) begin
                m_q.push_back(sda_in);
                if (m_q.size() == 8 && split_pack) begin
                    m_word = '0;
                    for (int i = 0; i < 7; i++) m_word[6-i] = m_q[i];
                    m_word[8] = m_q[7];
                end
                if (m_q.size() == 9) begin
                    if (split_pack && !ack_std_view) begin
                        for (int i = 0; i < 7; i++) m_word[6-i] = m_q[i];
                        m_word[8] = m_q[7];
                        m_word[7] = m_q[8];
                    end else begin
                        for (int i = 0; i < 8; i++) m_word[7-i] = m_q[i];
                        m_word[8] = m_q[8];
                    end
                    m_done = 1'b1;
                    m_q.delete();
                end
            end
            if (tx_load) begin m_txw = tx_data; m_pos = 0; m_q.delete(); end
            if (preset_we && i2c_mode && !enable) begin m_lvl = preset_level; m_wait = 0; end
        end
    end

    // compare every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " sda_drive_low"}, 32'(sda_drive_low), 32'(!sda_release && !m_lvl));
            chk({cur_req, " rx_word"}, 32'(rx_word), 32'(m_word));
            chk({cur_req, " rx_done"}, 32'(rx_done), 32'(m_done));
            if (rx_done) done_seen++;
        end
    end

    task automatic pulse_load(input logic [8:0] v);
        tx_data = v; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic run_bit(input logic b, input int gap);
        scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
        repeat (gap) @(negedge clk);
        sda_in = b; scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_bits(input logic [8:0] pat, input int n, input int gap);
        for (int i = 0; i < n; i++) run_bit(pat[8-i], gap);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mis++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; i2c_mode = 1'b0; enable = 1'b0; scl_fall = 1'b0; scl_rise = 1'b0;
        div_tick = 1'b0; dly_sel = 3'd0; sda_release = 1'b0; preset_we = 1'b0;
        preset_level = 1'b1; tx_load = 1'b0; tx_data = '0; split_pack = 1'b0;
        ack_std_view = 1'b0; sda_in = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 reset sda", 32'(sda_drive_low), 32'd0);
        chk("R1 reset word", 32'(rx_word), 32'd0);
        chk("R1 reset done", 32'(rx_done), 32'd0);

        // R5 preset accepted / ignored
        cur_req = "R5";
        i2c_mode = 1'b1;
        preset_level = 1'b0; preset_we = 1'b1; @(negedge clk); preset_we = 1'b0;
        chk("R5 preset low accepted", 32'(sda_drive_low), 32'd1);
        enable = 1'b1; preset_level = 1'b1; preset_we = 1'b1; @(negedge clk); preset_we = 1'b0;
        chk("R5 preset ignored when enabled", 32'(sda_drive_low), 32'd1);
        enable = 1'b0; i2c_mode = 1'b0; preset_we = 1'b1; @(negedge clk); preset_we = 1'b0;
        chk("R5 preset ignored outside mode", 32'(sda_drive_low), 32'd1);
        i2c_mode = 1'b1; preset_we = 1'b1; @(negedge clk); preset_we = 1'b0;
        chk("R5 preset high accepted", 32'(sda_drive_low), 32'd0);
        enable = 1'b1;

        // R2 / R6 / R9 standard byte, no delay
        cur_req = "R2";
        pulse_load(9'h1A5);
        done_seen = 0;
        run_bits(9'h165, 9, 4);
        chk("R6 standard layout", 32'(rx_word), 32'h1B2);
        chk("R9 one pulse per byte", 32'(done_seen), 32'd1);
        run_bit(1'b0, 2);
        chk("R2 released after slot nine", 32'(sda_drive_low), 32'd0);

        // R3 delayed output
        cur_req = "R3";
        for (int d = 1; d < 8; d += 3) begin
            dly_sel = 3'(d);
            pulse_load(9'h0F3);
            run_bits(9'h0A7, 9, 20);
        end
        dly_sel = 3'd7; pulse_load(9'h055);
        run_bits(9'h1FF, 9, 2);
        repeat (20) @(negedge clk);
        dly_sel = 3'd0;

        // R4 forced release
        cur_req = "R4";
        sda_release = 1'b1;
        pulse_load(9'h000);
        run_bits(9'h165, 4, 4);
        chk("R4 released while zeros shift", 32'(sda_drive_low), 32'd0);
        run_bits(9'h165, 5, 4);
        sda_release = 1'b0;

        // R7 split layout
        cur_req = "R7";
        split_pack = 1'b1; ack_std_view = 1'b0;
        pulse_load(9'h0C3);
        run_bits(9'h165, 8, 4);
        chk("R7 split after eighth", 32'(rx_word), 32'h059);
        run_bit(1'b1, 4);
        chk("R7 split after ninth", 32'(rx_word), 32'h0D9);

        // R8 split with standard view at ninth edge
        cur_req = "R8";
        ack_std_view = 1'b1;
        pulse_load(9'h13C);
        run_bits(9'h165, 9, 4);
        chk("R8 standard view", 32'(rx_word), 32'h1B2);
        split_pack = 1'b0; ack_std_view = 1'b0;

        // R10 edges ignored while disabled
        cur_req = "R10";
        pulse_load(9'h000);
        run_bits(9'h0AA, 2, 3);
        enable = 1'b0;
        begin
            logic [8:0] w0; logic s0;
            w0 = rx_word; s0 = sda_drive_low;
            done_seen = 0;
            run_bits(9'h0F0, 9, 3);
            chk("R10 word unchanged", 32'(rx_word), 32'(w0));
            chk("R10 line unchanged", 32'(sda_drive_low), 32'(s0));
            chk("R10 no completion", 32'(done_seen), 32'd0);
        end
        enable = 1'b1;

        // R11 load restarts receive count
        cur_req = "R11";
        pulse_load(9'h1FF);
        run_bits(9'h000, 4, 3);
        pulse_load(9'h1FF);
        done_seen = 0;
        run_bits(9'h165, 9, 3);
        chk("R11 restart layout", 32'(rx_word), 32'h1B2);
        chk("R11 restart single pulse", 32'(done_seen), 32'd1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule